// File: doc/BRIEF.md
# Fractional-Increment Master Time Counter

This block keeps a free-running master time count that advances at a constant nominal rate, typically 6.144 MHz, while its own clock runs at whatever system frequency the board provides. The advance rate is an exact rational fraction of the clock. Each cycle a small phase accumulator gains a programmed numerator step. Whenever the accumulated phase reaches the programmed denominator, the denominator is taken back out and the count advances by one. Software picks the numerator and denominator that match the clock. Some examples: 8/25 at 19.2 MHz, 64/125 at 12 MHz, 768/1625 at 13 MHz, 192/625 at 20 MHz, 384/1625 at 26 MHz and 256/1125 at 27 MHz. When the slow reference is emulated from the system clock, the pair is 75/244.

The two ratio values sit in the low 12 bits of two 32-bit registers on a simple write/read register port. The wide count drives downstream timers directly through `count_o`. Software reads the count as two half-width words. Reading the low half captures the high half in the same cycle, so a later read of the high half belongs to the same instant. After reset the block uses 4/25, the pair for a 38.4 MHz clock.

Top module: `rtc_master_counter`

## Requirements
- R1: After reset `count_o` is 0, the numerator register reads 4 and the denominator register reads 25, so counting starts at the 4/25 ratio.
- R2: Starting from a cleared phase, N clock cycles advance the count by exactly floor(N × num / den), where num and den are the 12-bit fields. For example, 250 cycles at 8/25 give 80.
- R3: The exact-rate property holds for every ratio in the clock table, for the emulated-reference pair 75/244 and for the full-field pair 4095/4095.
- R4: A numerator field larger than the denominator field is clamped to the denominator. The count then advances once per clock and never by more than one in any clock.
- R5: While the denominator field is 0, the count holds its value.
- R6: A write to the numerator register (offset 0x10) or the denominator register (offset 0x14) clears the phase accumulator. The count does not advance in the clock of that write.
- R7: The ratio field is bits [11:0] of each register. Bits [31:12] are stored and read back exactly as written, and they have no effect on the count rate.
- R8: A read of offset 0x00 returns, one clock after `rd_en`, the low half of the count as it stood before that clock edge, zero-extended. The same read captures the high half. A read of offset 0x04 returns the captured high half, even after the count has carried into it. `rd_data` keeps its value in clocks without `rd_en`.
- R9: A read of any other offset returns 0. A write to any other offset leaves both ratio registers and the count progression unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of any supported frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data, valid one clock after `rd_en` |
| count_o | output | CNT_W | Live master count |

## Verification
Two pairs of events can fall in the same clock edge. A ratio write can land on the edge where the accumulator would roll over, and a low-half read can land on the edge where the count advances. The bench provokes the first pair by rewriting the numerator exactly one step before a rollover; the write must win, so the count stays flat and then follows the clean-phase rate. It provokes the second pair by reading the count while the ratio is 1/1, so every edge advances the count, and by reading across a carry into the high half. A behavioural model compares the pre-edge value, the captured high half and the live count on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   // Byte offsets of the register port. The ratio offsets are the ones the
   // boot software programs; the count offsets are local to this block.
   localparam logic [7:0] OFS_CNT_LO = 8'h00;
   localparam logic [7:0] OFS_CNT_HI = 8'h04;
   localparam logic [7:0] OFS_NUM    = 8'h10;
   localparam logic [7:0] OFS_DEN    = 8'h14;
endpackage

// File: rtl/rtc_ratio_regs.sv
module rtc_ratio_regs
   import rtc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int FIELD_W   = 12,
   parameter int RESET_NUM = 4,
   parameter int RESET_DEN = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] num_reg,
   output logic [DATA_W-1:0] den_reg,
   output logic [FIELD_W-1:0] num_f,
   output logic [FIELD_W-1:0] den_f,
   output logic              ratio_wr
);
   logic hit_num, hit_den;

   assign hit_num  = wr_en && (wr_addr == ADDR_W'(OFS_NUM));
   assign hit_den  = wr_en && (wr_addr == ADDR_W'(OFS_DEN));
   assign ratio_wr = hit_num || hit_den;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_reg <= DATA_W'(RESET_NUM);
         den_reg <= DATA_W'(RESET_DEN);
      end else begin
         if (hit_num) num_reg <= wr_data;
         if (hit_den) den_reg <= wr_data;
      end
   end

   assign num_f = num_reg[FIELD_W-1:0];
   assign den_f = den_reg[FIELD_W-1:0];
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
   parameter int FIELD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [FIELD_W-1:0] num,
   input  logic [FIELD_W-1:0] den,
   output logic               tick
);
   localparam int ACC_W = FIELD_W + 1;

   logic [ACC_W-1:0]   acc;
   logic [FIELD_W-1:0] step;
   logic [ACC_W-1:0]   sum;
   logic               roll;
   logic               den_zero;

   assign den_zero = (den == '0);
   assign step     = (num > den) ? den : num;
   assign sum      = acc + {1'b0, step};
   assign roll     = !den_zero && (sum >= {1'b0, den});
   assign tick     = roll && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc <= '0;
      end else if (!den_zero) begin
         acc <= roll ? (sum - {1'b0, den}) : sum;
      end
   end

   // R4
   acc_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!den_zero) |-> (acc < {1'b0, den}));
   // R6
   clear_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
   parameter int CNT_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               latch_hi,
   output logic [CNT_W-1:0]   count,
   output logic [CNT_W/2-1:0] hi_hold
);
   localparam int HALF_W = CNT_W / 2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         hi_hold <= '0;
      end else begin
         if (tick)     count   <= count + CNT_W'(1);
         if (latch_hi) hi_hold <= count[CNT_W-1:HALF_W];
      end
   end

   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/rtc_master_counter.sv
module rtc_master_counter
   import rtc_pkg::*;
#(
   parameter int CNT_W     = 64,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int FIELD_W   = 12,
   parameter int RESET_NUM = 4,
   parameter int RESET_DEN = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count_o
);
   localparam int HALF_W = CNT_W / 2;

   if (CNT_W % 2 != 0) begin : g_bad_cnt_w
      $error("CNT_W must be even");
   end
   if (HALF_W > DATA_W) begin : g_bad_half_w
      $error("half of CNT_W must fit in DATA_W");
   end
   if (FIELD_W >= DATA_W) begin : g_bad_field_w
      $error("FIELD_W must be narrower than DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("ADDR_W must reach offset 0x14");
   end

   logic [DATA_W-1:0]  num_reg, den_reg;
   logic [FIELD_W-1:0] num_f, den_f;
   logic               ratio_wr;
   logic               tick;
   logic               latch_hi;
   logic [HALF_W-1:0]  hi_hold;
   logic [DATA_W-1:0]  lo_ext, hi_ext;

   rtc_ratio_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
      .RESET_NUM(RESET_NUM), .RESET_DEN(RESET_DEN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .num_reg(num_reg), .den_reg(den_reg),
      .num_f(num_f), .den_f(den_f), .ratio_wr(ratio_wr)
   );

   rtc_frac_accum #(.FIELD_W(FIELD_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .clr(ratio_wr),
      .num(num_f), .den(den_f), .tick(tick)
   );

   assign latch_hi = rd_en && (rd_addr == ADDR_W'(OFS_CNT_LO));

   rtc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .latch_hi(latch_hi),
      .count(count_o), .hi_hold(hi_hold)
   );

   if (HALF_W == DATA_W) begin : g_word_full
      assign lo_ext = count_o[HALF_W-1:0];
      assign hi_ext = hi_hold;
   end else begin : g_word_pad
      assign lo_ext = {{(DATA_W-HALF_W){1'b0}}, count_o[HALF_W-1:0]};
      assign hi_ext = {{(DATA_W-HALF_W){1'b0}}, hi_hold};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         if (rd_addr == ADDR_W'(OFS_CNT_LO))      rd_data <= lo_ext;
         else if (rd_addr == ADDR_W'(OFS_CNT_HI)) rd_data <= hi_ext;
         else if (rd_addr == ADDR_W'(OFS_NUM))    rd_data <= num_reg;
         else if (rd_addr == ADDR_W'(OFS_DEN))    rd_data <= den_reg;
         else                                     rd_data <= '0;
      end
   end

   // R5
   den_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (den_f == '0) |=> $stable(count_o));
   // R6
   write_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_wr |=> $stable(count_o));
   // R8
   lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_hi |=> (rd_data[HALF_W-1:0] == $past(count_o[HALF_W-1:0])));
   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/rtc_master_counter_tb.sv
module rtc_master_counter_tb;
   localparam int CW = 20;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int HW = CW / 2;
   localparam longint unsigned CMASK = (64'd1 << CW) - 1;
   localparam longint unsigned HMASK = (64'd1 << HW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] count_o;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtc_master_counter #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .count_o(count_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // behavioural reference
   longint unsigned m_cnt = 0, m_hi = 0, m_rd = 0;
   int              m_acc = 0;
   logic [31:0]     m_num = 32'd4, m_den = 32'd25;

   always @(posedge clk) begin
      int n, d, e, s;
      if (!rst_n) begin
         m_cnt = 0; m_hi = 0; m_rd = 0; m_acc = 0;
         m_num = 32'd4; m_den = 32'd25;
      end else begin
         if (rd_en) begin
            case (rd_addr)
               8'h00: begin m_rd = m_cnt & HMASK; m_hi = m_cnt >> HW; end
               8'h04: m_rd = m_hi;
               8'h10: m_rd = m_num;
               8'h14: m_rd = m_den;
               default: m_rd = 0;
            endcase
         end
         n = int'(m_num & 32'hFFF);
         d = int'(m_den & 32'hFFF);
         if (wr_en && (wr_addr == 8'h10 || wr_addr == 8'h14)) begin
            m_acc = 0;
         end else if (d != 0) begin
            e = (n > d) ? d : n;
            s = m_acc + e;
            if (s >= d) begin
               m_acc = s - d;
               m_cnt = (m_cnt + 1) & CMASK;
            end else begin
               m_acc = s;
            end
         end
         if (wr_en && wr_addr == 8'h10) m_num = wr_data;
         if (wr_en && wr_addr == 8'h14) m_den = wr_data;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk("model count_o (R2 R6)", longint'(count_o), longint'(m_cnt));
         chk("model rd_data (R8 R9)", longint'(rd_data), longint'(m_rd));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         finish_run();
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
      wr_en = 1'b1; wr_addr = a; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic run_ratio(input string req, input int n, input int d, input int cycles);
      longint unsigned c0, exp;
      wr(8'h10, DW'(n));
      wr(8'h14, DW'(d));
      c0 = count_o;
      repeat (cycles) @(negedge clk);
      if (d == 0) exp = 0;
      else if (n > d) exp = cycles;
      else exp = (longint'(cycles) * n) / d;
      chk(req, longint'((count_o - c0) & CMASK), longint'(exp));
   endtask

   initial begin
      logic [DW-1:0]   v;
      longint unsigned c0, x, k;
      repeat (4) @(negedge clk);
      chk("R1 count at reset", longint'(count_o), 0);
      rst_n = 1'b1;
      c0 = count_o;
      repeat (100) @(negedge clk);
      chk("R1 R2 default 4/25 over 100", longint'(count_o - c0), 16);
      rd(8'h10, v); chk("R1 numerator reset", longint'(v), 4);
      rd(8'h14, v); chk("R1 denominator reset", longint'(v), 25);

      run_ratio("R2 8/25 over 250", 8, 25, 250);
      run_ratio("R3 64/125 over 375", 64, 125, 375);
      run_ratio("R3 768/1625 over 1625", 768, 1625, 1625);
      run_ratio("R3 384/1625 over 1625", 384, 1625, 1625);
      run_ratio("R3 192/625 over 700", 192, 625, 700);
      run_ratio("R3 75/244 over 488", 75, 244, 488);
      run_ratio("R3 4095/4095 over 50", 4095, 4095, 50);
      run_ratio("R4 30/25 clamp over 40", 30, 25, 40);
      run_ratio("R4 4095/1 clamp over 33", 4095, 1, 33);
      run_ratio("R5 den zero holds", 7, 0, 60);

      // R6: rewrite one step before a rollover
      run_ratio("R6 setup 4/25 over 24", 4, 25, 24);
      c0 = count_o;
      wr(8'h10, 32'd4);
      chk("R6 no step in write clock", longint'(count_o), longint'(c0));
      c0 = count_o;
      repeat (24) @(negedge clk);
      chk("R6 clean phase after write", longint'(count_o - c0), 3);

      // R7: upper bits stored, ignored for rate
      wr(8'h10, 32'hFFFFF008);
      wr(8'h14, 32'h12300019);
      rd(8'h10, v); chk("R7 numerator upper bits", longint'(v), longint'(32'hFFFFF008));
      rd(8'h14, v); chk("R7 denominator upper bits", longint'(v), longint'(32'h12300019));
      wr(8'h14, 32'h12300019);
      c0 = count_o;
      repeat (250) @(negedge clk);
      chk("R7 rate uses low field only", longint'(count_o - c0), 80);

      // R8: coherent split read across a carry
      wr(8'h10, 32'd1);
      wr(8'h14, 32'd1);
      while (count_o[HW-1:0] != HW'(1020)) @(negedge clk);
      x = count_o;
      rd(8'h00, v);
      chk("R8 low half pre-edge", longint'(v), longint'(x & HMASK));
      k = x >> HW;
      repeat (10) @(negedge clk);
      chk("R8 carry reached high half", longint'((count_o >> HW) != k), 1);
      rd(8'h04, v);
      chk("R8 high half is captured value", longint'(v), longint'(k));
      x = count_o;
      rd(8'h00, v);
      rd(8'h04, v);
      chk("R8 high half after new capture", longint'(v), longint'(x >> HW));

      // R9: unmapped offsets
      rd(8'h08, v); chk("R9 unmapped read", longint'(v), 0);
      c0 = count_o;
      wr(8'h20, 32'hFFFFFFFF);
      chk("R9 unmapped write keeps stepping", longint'(count_o - c0), 1);
      rd(8'h10, v); chk("R9 numerator untouched", longint'(v), 1);
      rd(8'h14, v); chk("R9 denominator untouched", longint'(v), 1);

      @(negedge clk);
      finish_run();
   end
endmodule